// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets logic running on a single clock use an external asynchronous static RAM of 64K words by 16 bits with separate enables for the lower and upper byte. The host side presents one request at a time. Each request carries an address, a write flag, write data and a two-bit byte mask. The controller turns each request into a strobe sequence on the memory pins. The sequence lasts several clocks so that the memory's access time, write pulse width and data setup are met. It also arranges that the controller's data driver and the memory's output drivers are never on together.

The request port follows valid/ready rules. `req_ready` is high only while the controller is idle and does not depend on `req_valid`. A request is taken on a clock edge where both are high. The host must hold the request fields stable while `req_valid` is high and `req_ready` is low. The response port has no back-pressure. `rsp_valid` pulses for one clock when a read's data is captured or a write has finished, and the host must take `rsp_rdata` in that clock.

The memory data bus is split into three signals: `mem_dq_out`, `mem_dq_en` and `mem_dq_in`. Pad tristate buffers outside the block combine them.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and right after reset, `mem_cs_n`, `mem_we_n`, `mem_oe_n`, `mem_lb_n` and `mem_ub_n` are high, `mem_dq_en` is low, `rsp_valid` is low and `req_ready` is high.
- R2: `req_ready` is high only when no access is in progress, so it is low in every clock from the accepting edge until `rsp_valid` is seen. `rsp_valid` is high for exactly one clock per accepted request.
- R3: For a read accepted at edge k, `mem_cs_n` and `mem_oe_n` are low and `mem_we_n` is high for the two clocks after edges k and k+1. `mem_dq_in` is captured at edge k+2. `rsp_valid` and `rsp_rdata` appear in the clock after edge k+2.
- R4: Mask bit 0 drives `mem_lb_n` low and selects data bits 7:0. Mask bit 1 drives `mem_ub_n` low and selects data bits 15:8. On a read, a lane whose mask bit is clear returns zero in `rsp_rdata`.
- R5: For a write accepted at edge k with no turnaround, `mem_cs_n` and `mem_we_n` are low for the two clocks after edges k and k+1. Both are high in the one recovery clock after edge k+2. `mem_oe_n` stays high throughout. `rsp_valid` appears in the clock after edge k+3.
- R6: `mem_dq_en` is high only in write and recovery clocks. It is never high while `mem_oe_n` is low, nor while the memory could be driving the bus.
- R7: `mem_addr` equals the accepted address and does not change while `mem_cs_n` is low. `mem_we_n` is only low while `mem_cs_n` is low.
- R8: A write whose previous completed access was a read first spends one clock with all strobes high and the driver off. `mem_we_n` therefore first goes low in the second clock after acceptance, and `rsp_valid` comes one clock later than in R5.
- R9: A write with both mask bits clear runs the normal sequence but leaves every memory byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 100 MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte mask, bit 0 lower byte, bit 1 upper byte |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data, masked lanes zero |
| mem_addr | output | 16 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_en | output | 1 | Data driver enable |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
Full-word writes and reads give a baseline that separates a working strobe sequence from a broken one. Single-lane writes over existing words, and single-lane reads, show whether each byte strobe reaches the correct half of the bus and whether a disabled lane comes back as zero. The request stream alternates between reads and writes in both directions. A write after a read must show the turnaround clock, and a read after a write must not. A write with an empty mask, followed by a read of the same word, shows that such a request cannot modify memory.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = WORD_W / LANE_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_READ,
    ST_WRITE,
    ST_RECOV
  } seq_state_e;
endpackage

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned RD_CLKS   = 2,
  parameter int unsigned WR_CLKS   = 2,
  parameter int unsigned REC_CLKS  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              accept,
  output logic              capture,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              drive_en
);
  localparam int unsigned MAX_CLKS = (RD_CLKS > WR_CLKS) ?
                                     ((RD_CLKS > REC_CLKS) ? RD_CLKS : REC_CLKS) :
                                     ((WR_CLKS > REC_CLKS) ? WR_CLKS : REC_CLKS);
  localparam int unsigned CNT_W = $clog2(MAX_CLKS + 1);

  seq_state_e        state, state_nxt;
  logic [CNT_W-1:0]  cnt, cnt_nxt;
  logic              rd_last;
  logic              done_nxt;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign capture   = (state == ST_READ) && (cnt == CNT_W'(RD_CLKS - 1));

  always_comb begin
    state_nxt = state;
    cnt_nxt   = cnt;
    done_nxt  = 1'b0;
    case (state)
      ST_IDLE: begin
        cnt_nxt = '0;
        if (accept) begin
          if (!req_we)     state_nxt = ST_READ;
          else if (rd_last) state_nxt = ST_TURN;
          else             state_nxt = ST_WRITE;
        end
      end
      ST_TURN: begin
        state_nxt = ST_WRITE;
        cnt_nxt   = '0;
      end
      ST_READ: begin
        if (cnt == CNT_W'(RD_CLKS - 1)) begin
          state_nxt = ST_IDLE;
          cnt_nxt   = '0;
          done_nxt  = 1'b1;
        end else begin
          cnt_nxt = cnt + 1'b1;
        end
      end
      ST_WRITE: begin
        if (cnt == CNT_W'(WR_CLKS - 1)) begin
          state_nxt = ST_RECOV;
          cnt_nxt   = '0;
        end else begin
          cnt_nxt = cnt + 1'b1;
        end
      end
      ST_RECOV: begin
        if (cnt == CNT_W'(REC_CLKS - 1)) begin
          state_nxt = ST_IDLE;
          cnt_nxt   = '0;
          done_nxt  = 1'b1;
        end else begin
          cnt_nxt = cnt + 1'b1;
        end
      end
      default: begin
        state_nxt = ST_IDLE;
        cnt_nxt   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      rd_last   <= 1'b0;
      rsp_valid <= 1'b0;
      mem_addr  <= '0;
      mem_cs_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      drive_en  <= 1'b0;
    end else begin
      state     <= state_nxt;
      cnt       <= cnt_nxt;
      rsp_valid <= done_nxt;
      if (accept) mem_addr <= req_addr;
      if (capture) rd_last <= 1'b1;
      else if (state == ST_RECOV && done_nxt) rd_last <= 1'b0;
      mem_cs_n <= !(state_nxt == ST_READ || state_nxt == ST_WRITE);
      mem_we_n <= !(state_nxt == ST_WRITE);
      mem_oe_n <= !(state_nxt == ST_READ);
      drive_en <= (state_nxt == ST_WRITE) || (state_nxt == ST_RECOV);
    end
  end

  // R5, R7: write enable only inside chip select, output enable off during writes
  assert_we_inside_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n));

  // R6: no driver while the memory outputs may be on
  assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> mem_oe_n);

  // R7: address frozen while selected
  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  // R2: completion is a single-clock pulse
  assert_rsp_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R2: ready only while the bus is deselected
  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && !drive_en));

  // R6: a driven write is followed by a driven recovery clock, not by a read
  assert_recov_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) && drive_en |-> mem_cs_n);

  generate
    if (WR_CLKS >= 2) begin : g_we_width
      // R5: write pulse spans at least two clocks
      assert_we_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |=> !mem_we_n);
    end
  endgenerate
endmodule

// File: rtl/sram_lane.sv
module sram_lane
  import sram_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              lane_en,
  input  logic [LANE_W-1:0] wdata_in,
  input  logic              capture,
  input  logic [LANE_W-1:0] bus_in,
  output logic              strobe_n,
  output logic [LANE_W-1:0] wdata_out,
  output logic [LANE_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_n  <= 1'b1;
      wdata_out <= '0;
      rdata     <= '0;
    end else begin
      if (accept) begin
        strobe_n  <= !lane_en;
        wdata_out <= wdata_in;
      end
      if (capture) rdata <= strobe_n ? '0 : bus_in;
    end
  end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned RD_CLKS  = 2,
  parameter int unsigned WR_CLKS  = 2,
  parameter int unsigned REC_CLKS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [WORD_W-1:0] mem_dq_out,
  output logic              mem_dq_en,
  input  logic [WORD_W-1:0] mem_dq_in
);
  logic             accept;
  logic             capture;
  logic [LANES-1:0] lane_n;

  sram_seq #(
    .ADDR_W   (ADDR_W),
    .RD_CLKS  (RD_CLKS),
    .WR_CLKS  (WR_CLKS),
    .REC_CLKS (REC_CLKS)
  ) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .req_ready (req_ready),
    .accept    (accept),
    .capture   (capture),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .drive_en  (mem_dq_en)
  );

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      sram_lane i_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .lane_en   (req_be[g]),
        .wdata_in  (req_wdata[g*LANE_W +: LANE_W]),
        .capture   (capture),
        .bus_in    (mem_dq_in[g*LANE_W +: LANE_W]),
        .strobe_n  (lane_n[g]),
        .wdata_out (mem_dq_out[g*LANE_W +: LANE_W]),
        .rdata     (rsp_rdata[g*LANE_W +: LANE_W])
      );
    end
  endgenerate

  assign mem_lb_n = lane_n[0];
  assign mem_ub_n = lane_n[1];

  // R4: byte strobes frozen while the chip is selected
  assert_lane_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_lb_n) && $stable(mem_ub_n)));

  // R7: write data frozen while the driver is on
  assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_en && $past(mem_dq_en)) |-> $stable(mem_dq_out));
endmodule

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [15:0] mem_addr;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;
  logic [15:0] mem_dq_out;
  logic        mem_dq_en;
  logic [15:0] mem_dq_in;

  int checks = 0;
  int errors = 0;
  logic [15:0] ram [0:255];
  logic        mem_drives;

  always #5 clk = ~clk;

  sram_async_ctrl i_sram_async_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq_out(mem_dq_out), .mem_dq_en(mem_dq_en), .mem_dq_in(mem_dq_in)
  );

  // Memory model: drives junk on disabled lanes and all ones when not reading
  assign mem_drives = !mem_cs_n && !mem_oe_n && mem_we_n;
  assign mem_dq_in = mem_drives ?
    {(mem_ub_n ? 8'hA5 : ram[mem_addr[7:0]][15:8]),
     (mem_lb_n ? 8'h5A : ram[mem_addr[7:0]][7:0])} : 16'hFFFF;

  always @(negedge clk) begin
    if (!mem_cs_n && !mem_we_n && mem_dq_en) begin
      if (!mem_lb_n) ram[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
      if (!mem_ub_n) ram[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // contention monitor, R6
  int contention = 0;
  always @(negedge clk) if (rst_n && mem_dq_en && (mem_drives || !mem_oe_n)) contention++;

  // {we, be[1:0], addr[15:0], wdata[15:0], expected rdata[15:0], latency[3:0]}
  localparam int NV = 10;
  localparam logic [54:0] VEC [NV] = '{
    {1'b1, 2'b11, 16'h0010, 16'h1234, 16'h0000, 4'd4},
    {1'b1, 2'b11, 16'hFF20, 16'hABCD, 16'h0000, 4'd4},
    {1'b1, 2'b01, 16'h0010, 16'hFF99, 16'h0000, 4'd4},
    {1'b1, 2'b10, 16'hFF20, 16'h7700, 16'h0000, 4'd4},
    {1'b0, 2'b11, 16'h0010, 16'h0000, 16'h1299, 4'd3},
    {1'b0, 2'b11, 16'hFF20, 16'h0000, 16'h77CD, 4'd3},
    {1'b0, 2'b01, 16'hFF20, 16'h0000, 16'h00CD, 4'd3},
    {1'b0, 2'b10, 16'h0010, 16'h0000, 16'h1200, 4'd3},
    {1'b1, 2'b00, 16'h0010, 16'h0000, 16'h0000, 4'd5},
    {1'b0, 2'b11, 16'h0010, 16'h0000, 16'h1299, 4'd3}
  };

  task automatic run_vec(input logic [54:0] v);
    logic        we;
    logic [1:0]  be;
    logic [15:0] addr, exp_d;
    int          exp_lat, lat, we_first, we_cnt, oe_cnt;
    bit          ready_ok, addr_ok, oe_ok, strb_ok;
    we = v[54]; be = v[53:52]; addr = v[51:36]; exp_d = v[19:4];
    exp_lat = int'(v[3:0]);
    lat = 0; we_first = 0; we_cnt = 0; oe_cnt = 0;
    ready_ok = 1; addr_ok = 1; oe_ok = 1; strb_ok = 1;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_be = be; req_addr = addr; req_wdata = v[35:20];
    forever begin
      @(negedge clk);
      req_valid = 1'b0;
      req_addr = 16'h0BAD; req_wdata = 16'h0BAD; req_be = ~be;
      lat++;
      if (rsp_valid || lat > 10) break;
      if (req_ready) ready_ok = 0;
      if (!mem_cs_n && mem_addr != addr) addr_ok = 0;
      if (!mem_cs_n && (mem_lb_n != !be[0] || mem_ub_n != !be[1])) strb_ok = 0;
      if (!mem_we_n) begin
        we_cnt++;
        if (we_first == 0) we_first = lat;
        if (!mem_oe_n) oe_ok = 0;
      end
      if (!mem_oe_n) oe_cnt++;
    end
    chk(lat == exp_lat, we ? (exp_lat == 5 ? "R8 latency" : "R5 latency") : "R3 latency",
        lat, exp_lat);
    chk(ready_ok, "R2 ready low while busy", ready_ok, 1);
    chk(addr_ok, "R7 address", addr_ok, 1);
    chk(strb_ok, "R4 byte strobes", strb_ok, 1);
    if (we) begin
      chk(we_cnt == 2 && oe_cnt == 0 && oe_ok, "R5 write strobes", we_cnt, 2);
      chk(we_first == exp_lat - 3, "R8 write start", we_first, exp_lat - 3);
    end else begin
      chk(oe_cnt == 2 && we_cnt == 0, "R3 read strobes", oe_cnt, 2);
      chk(rsp_rdata == exp_d, be == 2'b11 ? "R3 read data" :
          (exp_d == 16'h1299 ? "R9 empty-mask write" : "R4 lane mask"), rsp_rdata, exp_d);
    end
    @(negedge clk);
    chk(!rsp_valid, "R2 pulse width", rsp_valid, 0);
  endtask

  bit done = 0;

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 16'h0000;
    repeat (3) @(negedge clk);
    // R1: reset values while held in reset
    chk(mem_cs_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_en,
        "R1 strobes in reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_en},
        6'b111110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && mem_cs_n && !mem_dq_en, "R1 after reset",
        {req_ready, rsp_valid, mem_cs_n, mem_dq_en}, 4'b1010);
    for (int i = 0; i < NV; i++) run_vec(VEC[i]);
    // R9: empty mask left the upper word too
    chk(ram[8'h10] == 16'h1299, "R9 memory unchanged", ram[8'h10], 16'h1299);
    // R6: driver never overlapped a memory read
    chk(contention == 0, "R6 bus contention", contention, 0);
    // R2: idle with no request stays ready and silent
    repeat (4) @(negedge clk);
    chk(req_ready && !rsp_valid && mem_cs_n, "R2 idle", {req_ready, rsp_valid}, 2'b10);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule